// File: doc/BRIEF.md
# Opcode Fetch Monitor and Restart Register

This block sits beside an 8-bit processor and watches its bus. The processor marks the final cycle of each instruction with a last-cycle indicator. The block delays that indicator by one clock, so the following cycle is known to be an opcode fetch. On every such fetch the block does two things:

- It looks up the opcode on the data bus in a 256-entry bitmap of forbidden opcodes. A forbidden opcode produces a fixed-length reset request to the processor. It never raises an interrupt.
- It records the bus address of the fetch in a restart register.

When the memory system signals a page fault, the restart register freezes. Supervisor code can then read the address of the instruction to run again. The register stays frozen until software releases it with a clear strobe.

The bitmap is loaded one byte at a time through a small write port, and only while the monitor is disabled. Operand and data cycles are never looked up. The block does not decode instructions beyond their legality.

Top module: `opfetch_guard`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `cpu_reset_req` low, `frozen` low and `restart_addr` zero.
- R2: A cycle is an opcode fetch only if `last_cycle` was high in the cycle before it and `enable` is high in it. A byte on the data bus in any other cycle is never compared against the bitmap.
- R3: Bitmap bit N set to 1 marks opcode N as forbidden. The bit sits at bit position N[2:0] of byte N[7:3], and bit 0 is the least significant bit. When a fetch carries a forbidden opcode, `cpu_reset_req` goes high in the second cycle after the fetch cycle.
- R4: `cpu_reset_req` stays high for exactly RST_PULSE (default 4) consecutive cycles. A forbidden fetch that is evaluated while the pulse is active neither extends the pulse nor restarts it.
- R5: Each opcode fetch that occurs while `frozen` is low loads the fetch's `bus_addr` into `restart_addr`, and the new value is visible in the next cycle.
- R6: `page_fault` high together with `enable` sets `frozen` in the next cycle. While `frozen` is high, `restart_addr` does not change. If the faulting cycle is itself an unfrozen fetch, that fetch's address is still captured.
- R7: `restart_clr` clears `frozen` in the next cycle. If an enabled page fault occurs in the same cycle, the fault wins and `frozen` stays high.
- R8: `map_we` writes `map_byte` into byte `map_idx` of the bitmap only while `enable` is low. A write attempted while `enable` is high is discarded.
- R9: While `enable` is low, the block captures no address, requests no reset and ignores `page_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Monitor enable; the bitmap can be loaded only while this is low |
| bus_addr | input | ADDR_W | Processor address bus |
| bus_data | input | OP_W | Processor data bus |
| last_cycle | input | 1 | High in the final bus cycle of each instruction |
| page_fault | input | 1 | Page fault from the memory mapper |
| restart_clr | input | 1 | Software strobe that releases the frozen restart register |
| map_we | input | 1 | Bitmap byte write strobe |
| map_idx | input | OP_W-3 | Bitmap byte index |
| map_byte | input | 8 | Bitmap byte; bit k covers opcode {map_idx, k} |
| cpu_reset_req | output | 1 | Reset request pulse to the processor |
| restart_addr | output | ADDR_W | Address of the most recent captured opcode fetch |
| frozen | output | 1 | Restart register is held after a page fault |

## Verification
The assertions assume that `last_cycle` is low during reset, so that the first cycle after reset is never mistaken for an opcode fetch. They also assume that the bitmap has been fully loaded before the monitor is enabled, so a lookup never reads an unwritten byte. The bench loads all 32 bytes with `enable` low and holds `last_cycle` low throughout reset. It then builds its traffic from whole instructions of one to three bus cycles, where only the final cycle carries `last_cycle`. Forbidden values are placed deliberately in operand positions, and page faults and clears are issued at random.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [0:0] {
    RS_TRACK  = 1'b0,
    RS_FROZEN = 1'b1
  } restart_state_t;

  localparam int BYTE_W = 8;
  localparam int BYTE_SEL_W = 3;
endpackage

// File: rtl/opf_fetch_detect.sv
module opf_fetch_detect #(
  parameter int ADDR_W = 16,
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              last_cycle,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [OP_W-1:0]   bus_data,
  output logic              fetch_v,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [OP_W-1:0]   fetch_op
);
  // Delayed end-of-instruction marker: the cycle after it is a fetch.
  logic last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= last_cycle;
  end

  assign fetch_v    = last_q & enable;
  assign fetch_addr = bus_addr;
  assign fetch_op   = bus_data;
endmodule

// File: rtl/opf_illegal_map.sv
module opf_illegal_map #(
  parameter int OP_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [OP_W-opf_pkg::BYTE_SEL_W-1:0] wr_idx,
  input  logic [opf_pkg::BYTE_W-1:0]      wr_byte,
  input  logic                            rd_v,
  input  logic [OP_W-1:0]                 rd_op,
  output logic                            hit
);
  localparam int SEL_W   = opf_pkg::BYTE_SEL_W;
  localparam int IDX_W   = OP_W - SEL_W;
  localparam int N_BYTES = (1 << OP_W) / opf_pkg::BYTE_W;

  logic [opf_pkg::BYTE_W-1:0] mem [N_BYTES];
  logic [opf_pkg::BYTE_W-1:0] rd_q;
  logic [SEL_W-1:0]           sel_q;
  logic                       v_q;
  logic [IDX_W-1:0]           rd_idx;

  assign rd_idx = rd_op[OP_W-1:SEL_W];

  // Synchronous write and read, no reset on the array: block RAM shape.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_byte;
    rd_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      v_q   <= 1'b0;
    end else begin
      sel_q <= rd_op[SEL_W-1:0];
      v_q   <= rd_v;
    end
  end

  assign hit = v_q & rd_q[sel_q];
endmodule

// File: rtl/opf_reset_pulse.sv
module opf_reset_pulse #(
  parameter int PULSE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic req
);
  localparam int CW = $clog2(PULSE + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req    <= 1'b0;
      left_q <= '0;
    end else if (req) begin
      if (left_q == '0) req <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end else if (trig) begin
      req    <= 1'b1;
      left_q <= CW'(PULSE - 1);
    end
  end
endmodule

// File: rtl/opf_restart_reg.sv
module opf_restart_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cap_v,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              fault,
  input  logic              clr,
  output logic [ADDR_W-1:0] restart_addr,
  output logic              frozen
);
  import opf_pkg::*;

  restart_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= RS_TRACK;
      restart_addr <= '0;
    end else begin
      if (cap_v && state_q == RS_TRACK) restart_addr <= cap_addr;
      if (fault && enable) state_q <= RS_FROZEN;
      else if (clr)        state_q <= RS_TRACK;
    end
  end

  assign frozen = (state_q == RS_FROZEN);
endmodule

// File: rtl/opfetch_guard.sv
module opfetch_guard #(
  parameter int ADDR_W = 16,
  parameter int OP_W = 8,
  parameter int RST_PULSE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [OP_W-1:0]   bus_data,
  input  logic              last_cycle,
  input  logic              page_fault,
  input  logic              restart_clr,
  input  logic              map_we,
  input  logic [OP_W-4:0]   map_idx,
  input  logic [7:0]        map_byte,
  output logic              cpu_reset_req,
  output logic [ADDR_W-1:0] restart_addr,
  output logic              frozen
);
  logic              fetch_v;
  logic [ADDR_W-1:0] fetch_addr;
  logic [OP_W-1:0]   fetch_op;
  logic              hit;
  logic              load_ok;

  assign load_ok = map_we & ~enable;

  opf_fetch_detect #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_detect (
    .clk(clk), .rst(rst), .enable(enable), .last_cycle(last_cycle),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .fetch_v(fetch_v), .fetch_addr(fetch_addr), .fetch_op(fetch_op)
  );

  opf_illegal_map #(.OP_W(OP_W)) u_map (
    .clk(clk), .rst(rst), .wr_en(load_ok), .wr_idx(map_idx),
    .wr_byte(map_byte), .rd_v(fetch_v), .rd_op(fetch_op), .hit(hit)
  );

  opf_reset_pulse #(.PULSE(RST_PULSE)) u_pulse (
    .clk(clk), .rst(rst), .trig(hit), .req(cpu_reset_req)
  );

  opf_restart_reg #(.ADDR_W(ADDR_W)) u_restart (
    .clk(clk), .rst(rst), .enable(enable), .cap_v(fetch_v),
    .cap_addr(fetch_addr), .fault(page_fault), .clr(restart_clr),
    .restart_addr(restart_addr), .frozen(frozen)
  );
endmodule

// File: rtl/opfetch_guard_chk.sv
module opfetch_guard_chk #(
  parameter int ADDR_W = 16,
  parameter int RST_PULSE = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              last_cycle,
  input logic              page_fault,
  input logic              restart_clr,
  input logic              cpu_reset_req,
  input logic [ADDR_W-1:0] restart_addr,
  input logic              frozen
);
  int   hi_cnt;
  logic lc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= 0;
      lc_q   <= 1'b0;
    end else begin
      hi_cnt <= cpu_reset_req ? hi_cnt + 1 : 0;
      lc_q   <= last_cycle;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_reset_req && !frozen && restart_addr == '0));

  p_pulse_len_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_reset_req) |-> hi_cnt == RST_PULSE);

  p_pulse_max_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_reset_req |-> hi_cnt < RST_PULSE);

  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (lc_q && enable && !frozen) |=> restart_addr == $past(bus_addr));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    frozen |=> $stable(restart_addr));

  p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (page_fault && enable) |=> frozen);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (restart_clr && !(page_fault && enable)) |=> !frozen);

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!enable && !frozen) |=> !frozen);

  p_enabled_trap_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_reset_req) |-> $past(enable, 2));
endmodule

bind opfetch_guard opfetch_guard_chk #(.ADDR_W(ADDR_W), .RST_PULSE(RST_PULSE)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .bus_addr(bus_addr),
  .last_cycle(last_cycle), .page_fault(page_fault), .restart_clr(restart_clr),
  .cpu_reset_req(cpu_reset_req), .restart_addr(restart_addr), .frozen(frozen)
);

// File: tb/test_opfetch_guard.sv
module test_opfetch_guard;
  localparam int AW = 16;
  localparam int PULSE = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1, enable = 1'b0, last_cycle = 1'b0;
  logic          page_fault = 1'b0, restart_clr = 1'b0, map_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_data = '0, map_byte = '0;
  logic [4:0]    map_idx = '0;
  logic          cpu_reset_req, frozen;
  logic [AW-1:0] restart_addr;

  opfetch_guard #(.ADDR_W(AW), .OP_W(8), .RST_PULSE(PULSE)) i_opfetch_guard (
    .clk(clk), .rst(rst), .enable(enable), .bus_addr(bus_addr),
    .bus_data(bus_data), .last_cycle(last_cycle), .page_fault(page_fault),
    .restart_clr(restart_clr), .map_we(map_we), .map_idx(map_idx),
    .map_byte(map_byte), .cpu_reset_req(cpu_reset_req),
    .restart_addr(restart_addr), .frozen(frozen)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0, cmp_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model.
  bit          ill [256];
  int          m_left = 0;
  bit          m_hit = 0, m_lic = 0, m_frz = 0;
  logic [AW-1:0] m_ra = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_left = 0; m_hit = 0; m_lic = 0; m_frz = 0; m_ra = '0;
    end else begin
      if (m_left > 0) m_left--;
      else if (m_hit) m_left = PULSE;
      m_hit = m_lic && enable && ill[bus_data];
      if (m_lic && enable && !m_frz) m_ra = bus_addr;
      if (enable && page_fault) m_frz = 1;
      else if (restart_clr) m_frz = 0;
      m_lic = last_cycle;
    end
    if (map_we && !enable)
      for (int k = 0; k < 8; k++) ill[{map_idx, 3'(k)}] = map_byte[k];
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(cpu_reset_req == (m_left > 0), "R4 reset_req vs model", cpu_reset_req, m_left > 0);
      chk(restart_addr == m_ra, "R5 restart_addr vs model", restart_addr, m_ra);
      chk(frozen == m_frz, "R6 frozen vs model", frozen, m_frz);
    end
  end

  task automatic cyc(input logic [AW-1:0] a, input logic [7:0] d, input bit l,
                     input bit pf = 0, input bit cl = 0);
    @(negedge clk);
    bus_addr = a; bus_data = d; last_cycle = l; page_fault = pf; restart_clr = cl;
  endtask

  // One instruction: opcode fetch then nops operand cycles; last cycle marked.
  task automatic instr(input logic [AW-1:0] pc, input logic [7:0] op, input int nops,
                       input logic [7:0] opnd = 8'h01);
    cyc(pc, op, nops == 0);
    for (int i = 1; i <= nops; i++) cyc(pc + AW'(i), opnd, i == nops);
  endtask

  task automatic load(input logic [4:0] idx, input logic [7:0] b);
    @(negedge clk);
    map_we = 1; map_idx = idx; map_byte = b;
    @(negedge clk);
    map_we = 0;
  endtask

  // Runs idle cycles and returns when reset_req first rose (0 = never) and its length.
  task automatic watch(output int first, output int len);
    first = 0; len = 0;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      if (cpu_reset_req) begin
        if (first == 0) first = k;
        len++;
      end
      bus_data = 8'h00; last_cycle = 0; page_fault = 0; restart_clr = 0;
    end
  endtask

  int first, len;
  logic [AW-1:0] held;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!cpu_reset_req && !frozen && restart_addr == '0, "R1 reset state",
        {cpu_reset_req, frozen, restart_addr}, 0);
    cmp_on = 1;
    // Forbidden: 0x01, 0x87, 0xFF. All other bytes cleared.
    for (int i = 0; i < 32; i++) load(5'(i), 8'h00);
    load(5'd0, 8'h02);
    load(5'd16, 8'h80);
    load(5'd31, 8'h80);
    @(negedge clk); enable = 1;

    instr(16'h0100, 8'h10, 0);
    instr(16'h0101, 8'h20, 2);
    // R3: fetch of 0x87 traps two cycles later, R4 four cycles long.
    cyc(16'h0104, 8'h87, 1);
    watch(first, len);
    chk(first == 2, "R3 reset delay", first, 2);
    chk(len == PULSE, "R4 pulse length", len, PULSE);
    chk(restart_addr == 16'h0104, "R5 captured fetch address", restart_addr, 16'h0104);

    // R2: forbidden byte in operand positions only.
    cyc(16'h0200, 8'h30, 0);
    cyc(16'h0201, 8'h01, 0);
    cyc(16'h0202, 8'hFF, 1);
    watch(first, len);
    chk(first == 0, "R2 operands not checked", first, 0);

    // R4: back-to-back forbidden fetches do not stretch the pulse.
    cyc(16'h0300, 8'hFF, 1);
    cyc(16'h0301, 8'h01, 1);
    cyc(16'h0302, 8'h87, 1);
    cyc(16'h0303, 8'h01, 1);
    cyc(16'h0304, 8'h10, 0);
    watch(first, len);
    chk(len <= PULSE, "R4 no retrigger", len, PULSE);

    // R8: write while enabled is discarded; 0x10 stays allowed.
    load(5'd2, 8'h01);
    cyc(16'h0400, 8'h20, 1);
    cyc(16'h0401, 8'h10, 0);
    watch(first, len);
    chk(first == 0, "R8 enabled write ignored", first, 0);

    // R6/R7: fault freezes, later fetches held, clear releases.
    cyc(16'h0500, 8'h20, 1);
    cyc(16'h0501, 8'h21, 0, 1);
    @(negedge clk); last_cycle = 1; page_fault = 0;
    chk(frozen, "R6 frozen after fault", frozen, 1);
    held = restart_addr;
    chk(held == 16'h0501, "R6 fault-cycle fetch captured", held, 16'h0501);
    instr(16'h0600, 8'h22, 1);
    instr(16'h0602, 8'h23, 0);
    chk(restart_addr == held, "R6 held while frozen", restart_addr, held);
    cyc(16'h0700, 8'h00, 0, 1, 1);
    @(negedge clk); page_fault = 0; restart_clr = 0;
    chk(frozen, "R7 fault beats clear", frozen, 1);
    cyc(16'h0701, 8'h00, 0, 0, 1);
    @(negedge clk); restart_clr = 0;
    chk(!frozen, "R7 clear releases", frozen, 0);

    // R9: disabled monitor ignores fetches and faults.
    held = restart_addr;
    enable = 0;
    cyc(16'h0800, 8'h00, 1);
    cyc(16'h0801, 8'h87, 0, 1);
    watch(first, len);
    chk(first == 0 && !frozen && restart_addr == held, "R9 disabled idle",
        {first[7:0], frozen}, 0);
    enable = 1;

    // Random instruction stream.
    for (int n = 0; n < 600; n++) begin
      logic [7:0] op;
      op = 8'($urandom);
      if (($urandom % 8) == 0) op = 8'h87;
      instr(16'($urandom), op, int'($urandom % 3), 8'($urandom));
      if (($urandom % 16) == 0) cyc(16'($urandom), 8'($urandom), 0, 1, 0);
      if (($urandom % 10) == 0) cyc(16'($urandom), 8'($urandom), 1, 0, 1);
      if (($urandom % 50) == 0) begin
        @(negedge clk); enable = 0;
        cyc(16'($urandom), 8'($urandom), 1, 1, 0);
        @(negedge clk); enable = 1;
      end
    end
    watch(first, len);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule